// File: doc/BRIEF.md
# Flash Row-Write Controller with Key Unlock

This block is the write path of an on-chip program memory, as seen through a small byte-wide register file on a CPU bus. Software stores an address and a 16-bit word in registers. It then writes a two-byte key and sets a start bit. Each start that is accepted does one of two things. In staging mode it places the word into one of eight write latches. With staging mode cleared it burns the whole latch row into the memory array model. A start that is not accepted changes neither the latches nor the array, and it raises an error flag.

While an accepted operation runs, the block raises a stall output that freezes the CPU. A latch load stalls for one cycle. A row program stalls for a parameterised number of cycles. The CPU throws away the two instruction slots that follow the start write and continues at the third once the stall drops. A row program always starts at an address with its three low bits cleared. When the program finishes, every latch returns to the erased value, so any word that was not staged is written as all ones.

Register select codes on `bus_sel`: 0 control, 1 key, 2 address low, 3 address high, 4 data low byte, 5 data high byte. Control bits: 0 start (reads 1 while busy), 1 write enable, 2 staging mode, 3 error flag, 6 configuration-space select, 7 program-space select.

Top module: `flash_row_writer`

## Requirements
- R1: After reset, stall and wr_err are low, every register reads 0, every latch holds 16'hFFFF and every array word reads 16'hFFFF.
- R2: A control write with bit 0 set is accepted only if the two bus writes just before it were key writes of 8'h55 and then 8'hAA. Cycles with no bus write between these writes do not break the sequence.
- R3: A key write of any value other than 8'h55 that does not complete 8'h55-then-8'hAA, or a write to any non-key register, clears the unlock state.
- R4: A start is rejected when control bit 1 (write enable) is 0 in the same control write.
- R5: An accepted start with bit 2 set copies {data high, data low} into latch address[2:0] and leaves the array unchanged. Stall is high for exactly 1 cycle.
- R6: An accepted start with bit 2 clear writes all eight latches into the array at address[ADDR_W-1:3] with the low bits equal to the latch index. Stall and control bit 0 are high for exactly PROG_CYCLES cycles, and the array changes on the edge where stall falls.
- R7: When a row program completes, all eight latches return to 16'hFFFF.
- R8: A start is accepted only when bit 7 is 1 and bit 6 is 0 in the same control write.
- R9: A rejected start sets wr_err. A control write with bit 3 at 0 and no rejected start clears it, and a write with bit 3 at 1 keeps it.
- R10: Bus writes that arrive while stall is high are ignored by every register and by the unlock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 3 | Register select for writes |
| bus_wdata | input | 8 | Write data |
| rd_sel | input | 3 | Register select for readback |
| rd_data | output | 8 | Readback of the selected register |
| mem_addr | input | ADDR_W | Array read address |
| mem_q | output | 16 | Array word at mem_addr |
| stall | output | 1 | CPU stall while an operation is in progress |
| wr_err | output | 1 | Sticky rejected-start flag |

## Verification
A row program has three effects that all land on one clock edge: the array is written, all latches return to erased, and the stall is released. The bench programs a second row right after a first without staging anything. It also reads the array at the committed address on every cycle, and it counts stall cycles so that the release edge is placed exactly. Key writes and register writes sent during a stall check that no unlock progress and no register change leak into the cycle after release. The reference model is checked against the design on every clock.

// File: rtl/flw_pkg.sv
package flw_pkg;
  localparam int ROW_WORDS = 8;
  localparam int ROW_BITS  = $clog2(ROW_WORDS);
  localparam int WORD_W    = 16;

  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_KEY  = 3'd1,
    SEL_ADRL = 3'd2,
    SEL_ADRH = 3'd3,
    SEL_DATL = 3'd4,
    SEL_DATH = 3'd5
  } sel_e;

  localparam int CB_GO    = 0;
  localparam int CB_ARM   = 1;
  localparam int CB_STAGE = 2;
  localparam int CB_ERR   = 3;
  localparam int CB_CFG   = 6;
  localparam int CB_PSP   = 7;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  typedef enum logic [1:0] {UK_IDLE, UK_HALF, UK_OPEN} ukey_e;

  function automatic logic [WORD_W-1:0] join_word(input logic [7:0] lo, input logic [7:0] hi);
    return {hi, lo};
  endfunction

  function automatic logic [15:0] row_base(input logic [15:0] a);
    return {a[15:ROW_BITS], {ROW_BITS{1'b0}}};
  endfunction

  function automatic logic [ROW_BITS-1:0] latch_idx(input logic [15:0] a);
    return a[ROW_BITS-1:0];
  endfunction
endpackage

// File: rtl/flw_unlock.sv
module flw_unlock
  import flw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic       is_key,
  input  logic [7:0] key_val,
  output logic       unlocked
);
  ukey_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= UK_IDLE;
    end else if (bus_we) begin
      if (!is_key)                                  st <= UK_IDLE;
      else if (key_val == KEY_FIRST)                st <= UK_HALF;
      else if (key_val == KEY_SECOND && st == UK_HALF) st <= UK_OPEN;
      else                                          st <= UK_IDLE;
    end
  end

  assign unlocked = (st == UK_OPEN);

  // R2
  rose_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(bus_we && is_key && key_val == KEY_SECOND));

  // R3
  break_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !is_key) |=> !unlocked);
endmodule

// File: rtl/flw_latch_row.sv
module flw_latch_row
  import flw_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld,
  input  logic [ROW_BITS-1:0]     ld_idx,
  input  logic [W-1:0]            ld_word,
  input  logic                    clr_all,
  output logic [ROW_WORDS*W-1:0]  row_flat
);
  for (genvar g = 0; g < ROW_WORDS; g++) begin : g_lat
    logic [W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      q <= '1;
      else if (clr_all)                                q <= '1;
      else if (ld && ld_idx == ROW_BITS'(g))           q <= ld_word;
    end
    assign row_flat[g*W +: W] = q;
  end

  // R7
  latch_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (row_flat == '1));

  // R5
  latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !clr_all) |=> (row_flat[$past(ld_idx)*W +: W] == $past(ld_word)));
endmodule

// File: rtl/flw_prog_timer.sv
module flw_prog_timer #(
  parameter int PROG_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_load,
  input  logic start_row,
  output logic stall,
  output logic commit
);
  localparam int CW = $clog2(PROG_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      row_q <= 1'b0;
    end else if (start_row) begin
      cnt   <= CW'(PROG_CYCLES);
      row_q <= 1'b1;
    end else if (start_load) begin
      cnt   <= CW'(1);
      row_q <= 1'b0;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign stall  = (cnt != '0);
  assign commit = row_q && (cnt == CW'(1));

  // R5
  load_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_load |=> (stall && !commit) ##1 !stall);

  // R6
  commit_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !stall);
endmodule

// File: rtl/flw_array.sv
module flw_array
  import flw_pkg::*;
#(
  parameter int AW = 8,
  parameter int W  = WORD_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   commit,
  input  logic [AW-1:0]          row_addr,
  input  logic [ROW_WORDS*W-1:0] row_flat,
  input  logic [AW-1:0]          rd_addr,
  output logic [W-1:0]           rd_q
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (commit) begin
      for (int j = 0; j < ROW_WORDS; j++)
        mem[{row_addr[AW-1:ROW_BITS], ROW_BITS'(j)}] <= row_flat[j*W +: W];
    end
  end

  assign rd_q = mem[rd_addr];

  // R6
  row_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (row_addr[ROW_BITS-1:0] == '0));
endmodule

// File: rtl/flash_row_writer.sv
module flash_row_writer
  import flw_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PROG_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [2:0]        bus_sel,
  input  logic [7:0]        bus_wdata,
  input  logic [2:0]        rd_sel,
  output logic [7:0]        rd_data,
  input  logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_q,
  output logic              stall,
  output logic              wr_err
);
  logic       we_ok, is_key, unlocked;
  logic       go_wr, space_ok, accept, rej, acc_load, acc_row, commit;
  logic [7:0] adr_l, adr_h, dat_l, dat_h;
  logic       c_arm, c_stage, c_cfg, c_psp;
  logic [15:0] adr_full, row_full;
  logic [ROW_WORDS*WORD_W-1:0] row_flat;

  assign we_ok    = bus_we && !stall;
  assign is_key   = (bus_sel == SEL_KEY);
  assign go_wr    = we_ok && (bus_sel == SEL_CTRL) && bus_wdata[CB_GO];
  assign space_ok = bus_wdata[CB_PSP] && !bus_wdata[CB_CFG];
  assign accept   = go_wr && unlocked && bus_wdata[CB_ARM] && space_ok;
  assign rej      = go_wr && !accept;
  assign acc_load = accept && bus_wdata[CB_STAGE];
  assign acc_row  = accept && !bus_wdata[CB_STAGE];
  assign adr_full = {adr_h, adr_l};
  assign row_full = row_base(adr_full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adr_l <= '0; adr_h <= '0; dat_l <= '0; dat_h <= '0;
      c_arm <= 1'b0; c_stage <= 1'b0; c_cfg <= 1'b0; c_psp <= 1'b0;
      wr_err <= 1'b0;
    end else if (we_ok) begin
      unique case (bus_sel)
        SEL_CTRL: begin
          c_arm   <= bus_wdata[CB_ARM];
          c_stage <= bus_wdata[CB_STAGE];
          c_cfg   <= bus_wdata[CB_CFG];
          c_psp   <= bus_wdata[CB_PSP];
          wr_err  <= rej || (wr_err && bus_wdata[CB_ERR]);
        end
        SEL_ADRL: adr_l <= bus_wdata;
        SEL_ADRH: adr_h <= bus_wdata;
        SEL_DATL: dat_l <= bus_wdata;
        SEL_DATH: dat_h <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (rd_sel)
      SEL_CTRL: rd_data = {c_psp, c_cfg, 2'b00, wr_err, c_stage, c_arm, stall};
      SEL_ADRL: rd_data = adr_l;
      SEL_ADRH: rd_data = adr_h;
      SEL_DATL: rd_data = dat_l;
      SEL_DATH: rd_data = dat_h;
      default:  rd_data = 8'h00;
    endcase
  end

  flw_unlock u_unlock (
    .clk(clk), .rst_n(rst_n), .bus_we(we_ok), .is_key(is_key),
    .key_val(bus_wdata), .unlocked(unlocked)
  );

  flw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_load(acc_load), .start_row(acc_row),
    .stall(stall), .commit(commit)
  );

  flw_latch_row #(.W(WORD_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .ld(acc_load), .ld_idx(latch_idx(adr_full)),
    .ld_word(join_word(dat_l, dat_h)), .clr_all(commit), .row_flat(row_flat)
  );

  flw_array #(.AW(ADDR_W), .W(WORD_W)) u_array (
    .clk(clk), .rst_n(rst_n), .commit(commit), .row_addr(row_full[ADDR_W-1:0]),
    .row_flat(row_flat), .rd_addr(mem_addr), .rd_q(mem_q)
  );

  // R9
  reject_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rej |=> wr_err);

  // R10
  frozen_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable({adr_h, adr_l, dat_h, dat_l, c_arm, c_stage, c_cfg, c_psp}));

  // R6
  row_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_row |=> (stall && rd_data[CB_GO] == (rd_sel == SEL_CTRL)) or (stall && rd_sel != SEL_CTRL));
endmodule

// File: tb/flash_row_writer_tb_top.sv
module flash_row_writer_tb_top;
  localparam int AW = 8;
  localparam int PC = 12;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [2:0]    bus_sel = 3'd0, rd_sel = 3'd0;
  logic [7:0]    bus_wdata = 8'h00;
  logic [AW-1:0] mem_addr = '0;
  logic [7:0]    rd_data;
  logic [15:0]   mem_q;
  logic          stall, wr_err;

  always #10 clk = ~clk;

  flash_row_writer #(.ADDR_W(AW), .PROG_CYCLES(PC)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .rd_sel(rd_sel), .rd_data(rd_data), .mem_addr(mem_addr), .mem_q(mem_q),
    .stall(stall), .wr_err(wr_err)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_key, m_cnt, m_base;
  bit m_row, m_err;
  int m_lat [8];
  int m_mem [DEPTH];
  int m_reg [6];

  function automatic int exp_rd(int s);
    if (s == 0) return (m_reg[0] & 8'hC6) | (m_err ? 8 : 0) | (m_cnt != 0 ? 1 : 0);
    if (s >= 2 && s <= 5) return m_reg[s];
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_key = 0; m_cnt = 0; m_row = 0; m_err = 0; m_base = 0;
      foreach (m_lat[i]) m_lat[i] = 16'hFFFF;
      foreach (m_mem[i]) m_mem[i] = 16'hFFFF;
      foreach (m_reg[i]) m_reg[i] = 0;
    end else if (m_cnt > 0) begin
      if (m_cnt == 1 && m_row) begin
        for (int i = 0; i < 8; i++) begin
          m_mem[m_base + i] = m_lat[i];
          m_lat[i] = 16'hFFFF;
        end
      end
      m_cnt--;
    end else if (bus_we) begin
      int d, a;
      bit go, ok;
      d = bus_wdata;
      a = ((m_reg[3] << 8) | m_reg[2]);
      if (bus_sel == 3'd1) begin
        if (d == 8'h55) m_key = 1;
        else if (d == 8'hAA && m_key == 1) m_key = 2;
        else m_key = 0;
      end else begin
        if (bus_sel == 3'd0) begin
          go = d[0];
          ok = (m_key == 2) && d[1] && d[7] && !d[6];
          m_reg[0] = d;
          m_err = (go && !ok) ? 1'b1 : (m_err && d[3]);
          if (go && ok) begin
            if (d[2]) begin
              m_lat[a % 8] = (m_reg[5] << 8) | m_reg[4];
              m_cnt = 1; m_row = 0;
            end else begin
              m_cnt = PC; m_row = 1; m_base = (a % DEPTH) - (a % 8);
            end
          end
        end else if (bus_sel <= 3'd5) begin
          m_reg[bus_sel] = d;
        end
        m_key = 0;
      end
    end
  end

  // Per-clock comparison, away from the edge
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      check("R5 R6 stall vs model", stall, (m_cnt != 0));
      check("R9 err vs model", wr_err, m_err);
      check("R1 R10 readback vs model", rd_data, exp_rd(rd_sel));
      check("R6 R7 array vs model", mem_q, m_mem[mem_addr]);
    end
  end

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    bus_we = 1'b1; bus_sel = s; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic set_addr(input logic [15:0] a);
    wr(3'd3, a[15:8]); wr(3'd2, a[7:0]);
  endtask

  task automatic keyed_start(input logic [7:0] c, output int stall_cycles);
    wr(3'd1, 8'h55); wr(3'd1, 8'hAA); wr(3'd0, c);
    stall_cycles = 0;
    while (stall) begin stall_cycles++; @(negedge clk); end
  endtask

  task automatic load(input logic [15:0] a, input logic [15:0] w, output int sc);
    set_addr(a); wr(3'd4, w[7:0]); wr(3'd5, w[15:8]);
    keyed_start(8'h87, sc);
  endtask

  task automatic prog(input logic [15:0] a, output int sc);
    set_addr(a); keyed_start(8'h83, sc);
  endtask

  task automatic peek(input logic [AW-1:0] a, input logic [15:0] exp, input string req);
    mem_addr = a; #1;
    check(req, mem_q, exp);
  endtask

  function automatic logic [15:0] wa(int k);
    return 16'hC35A ^ (16'h1111 * k[15:0]);
  endfunction

  initial begin
    int sc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 stall", stall, 0);
    check("R1 err", wr_err, 0);
    for (int s = 0; s < 6; s++) begin rd_sel = s[2:0]; #1; check("R1 reg", rd_data, 0); end
    rd_sel = 3'd0;
    peek(8'h37, 16'hFFFF, "R1 array");

    // R2 R5: stage eight words of row 0x20
    for (int k = 0; k < 8; k++) begin
      load(16'h0020 + k[15:0], wa(k), sc);
      check("R5 load stall cycles", sc, 1);
    end
    peek(8'h23, 16'hFFFF, "R5 array untouched by load");
    // R6: program with unaligned address
    prog(16'h0023, sc);
    check("R6 program stall cycles", sc, PC);
    for (int k = 0; k < 8; k++) peek(8'h20 + k[7:0], wa(k), "R6 row word");

    // R7: partial row, unstaged words erased
    load(16'h004A, 16'h1234, sc);
    load(16'h004F, 16'hBEEF, sc);
    prog(16'h004D, sc);
    for (int k = 0; k < 8; k++)
      peek(8'h48 + k[7:0], (k == 2) ? 16'h1234 : (k == 7) ? 16'hBEEF : 16'hFFFF, "R7 partial row");
    prog(16'h0020, sc);
    for (int k = 0; k < 8; k++) peek(8'h20 + k[7:0], 16'hFFFF, "R7 latches erased after program");

    // R3: broken key sequences
    set_addr(16'h0060); wr(3'd4, 8'h11); wr(3'd5, 8'h22);
    wr(3'd1, 8'h55); wr(3'd4, 8'h11); wr(3'd1, 8'hAA); wr(3'd0, 8'h87);
    check("R3 intervening write rejects", wr_err, 1);
    check("R3 no stall", stall, 0);
    wr(3'd0, 8'h00);
    check("R9 err cleared", wr_err, 0);
    wr(3'd1, 8'hAA); wr(3'd1, 8'h55); wr(3'd0, 8'h87);
    check("R3 reversed order rejects", wr_err, 1);
    wr(3'd0, 8'h08);
    check("R9 err kept with bit3", wr_err, 1);
    wr(3'd1, 8'h55); wr(3'd1, 8'h12); wr(3'd1, 8'hAA); wr(3'd0, 8'h87);
    check("R3 wrong key rejects", wr_err, 1);
    wr(3'd0, 8'h00);

    // R4: write enable clear
    keyed_start(8'h85, sc);
    check("R4 no stall", sc, 0);
    check("R4 err", wr_err, 1);
    wr(3'd0, 8'h00);
    // R8: configuration space and data space
    keyed_start(8'hC7, sc);
    check("R8 cfg rejects", wr_err, 1);
    wr(3'd0, 8'h00);
    keyed_start(8'h07, sc);
    check("R8 data space rejects", wr_err, 1);
    wr(3'd0, 8'h00);
    prog(16'h0060, sc);
    peek(8'h60, 16'hFFFF, "R3 R4 R8 latch not loaded by rejected start");
    check("R9 accepted start leaves err low", wr_err, 0);

    // R10: writes during stall ignored
    set_addr(16'h0070);
    wr(3'd1, 8'h55); wr(3'd1, 8'hAA); wr(3'd0, 8'h83);
    wr(3'd2, 8'h99); wr(3'd1, 8'h55); wr(3'd1, 8'hAA);
    while (stall) @(negedge clk);
    rd_sel = 3'd2; #1;
    check("R10 address unchanged", rd_data, 8'h70);
    rd_sel = 3'd0;
    wr(3'd0, 8'h87);
    check("R10 key during stall ignored", wr_err, 1);

    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule